// File: doc/BRIEF.md
# Dithered Phase-Accumulator Clock Synthesizer

This block is a purely digital frequency synthesizer. An N-bit phase register gains a frequency control word K on every clock edge, modulo 2^N. Each carry out of that addition is reported as a one-cycle overflow pulse. The overflow also flips a toggle stage, which gives a square wave with an average rate of K·fclk/2^(N+1). The control word can be changed at any time. The new value is used from the next edge, and the phase register is never reset by the change, so frequency hops are phase-continuous.

To break up the periodic timing pattern of the plain output, one of two dither schemes can be switched on at run time. Both draw on an internal maximal-length LFSR that advances once per clock.

- **Phase dither** adds a random N-bit value to the extended phase after the register. Only the square wave moves. The stored phase and the overflow pulses are untouched.
- **Shaped frequency dither** passes a small random sample through a first-difference filter and adds the signed result to K before accumulation. The mean increment therefore stays equal to K.

Top module: `phacc_synth`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `acc_o` = 0, `ovf_o` = 0 and `sq_o` = 0.
- R2: When frequency dither is not active, `acc_o` after each edge equals its previous value plus `fcw_i` (as sampled at that edge), modulo 2^N.
- R3: When frequency dither is not active, `ovf_o` is 1 for exactly the cycle after an edge whose addition carried out of N bits, and 0 otherwise.
- R4: Without phase dither, `sq_o` inverts once for every overflow. It therefore equals bit N of the (N+1)-bit running sum of all increments since reset.
- R5: With no dither, 2^N edges after reset produce exactly K overflow pulses, and `acc_o` is back at 0.
- R6: With phase dither (`mode_i` = 2'b01, `dith_en_i` = 1), `acc_o` and `ovf_o` follow exactly the undithered sequence. `sq_o` is bit N of the (N+1)-bit phase plus a random N-bit value, so it departs from the undithered square wave.
- R7: With frequency dither (`mode_i` = 2'b10, `dith_en_i` = 1), the increment is K + r[n] − r[n−1]. Here r is a FD_W-bit random sample, and r[n−1] is taken as 0 at reset and in any cycle not spent in this mode. For 2^FD_W−1 ≤ K ≤ 2^N−2^FD_W, 2^N edges from reset still give exactly K overflows, while `acc_o` departs from the plain K·n sequence.
- R8: A change of `fcw_i` is used at the very next edge, without clearing `acc_o`. This holds even when that edge is one on which the old K would have wrapped.
- R9: Mode codes are 2'b00 plain, 2'b01 phase dither, 2'b10 frequency dither, and 2'b11 plain. With `dith_en_i` = 0, the block behaves as plain whatever `mode_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | ACC_W | Frequency control word K |
| mode_i | input | 2 | Dither scheme select (see R9) |
| dith_en_i | input | 1 | Dither enable; low forces plain operation |
| sq_o | output | 1 | Registered square-wave output |
| ovf_o | output | 1 | Registered one-cycle overflow pulse |
| acc_o | output | ACC_W | Registered phase register value |

## Verification
Two events can land in the same cycle: a change of the control word, and the edge on which the accumulator wraps. The bench runs K = 64 from reset until the register holds 192. It then raises K to 100 just before the edge on which 64 would have wrapped the register. The result is judged against an exact model: the register must hold 36, the overflow must fire, and the square wave must flip, all at that edge. A further hop to K = 7 confirms that the phase carries on from 36 rather than restarting.

// File: rtl/phacc_pkg.sv
package phacc_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_PHASE = 2'b01,
    MODE_FREQ  = 2'b10,
    MODE_SPARE = 2'b11
  } dith_mode_e;

  // Feedback masks for maximal-length shift registers (bit i set = stage i+1 tapped)
  function automatic logic [63:0] lfsr_mask(input int w);
    case (w)
      16:      return 64'h0000_D008;
      18:      return 64'h0002_0400;
      20:      return 64'h0009_0000;
      24:      return 64'h00E1_0000;
      32:      return 64'h8020_0003;
      default: return (64'h1 << (w - 1)) | (64'h1 << (w - 2));
    endcase
  endfunction

endpackage

// File: rtl/phacc_lfsr.sv
module phacc_lfsr #(
  parameter int W    = 16,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  import phacc_pkg::*;

  localparam logic [63:0]  MASK64  = lfsr_mask(W);
  localparam logic [W-1:0] MASK    = MASK64[W-1:0];
  localparam logic [W-1:0] SEED_W  = W'(SEED);
  localparam logic [W-1:0] SEED_NZ = (SEED_W == '0) ? W'(1) : SEED_W;

  always_ff @(posedge clk) begin
    if (rst) state_o <= SEED_NZ;
    else     state_o <= {state_o[W-2:0], ^(state_o & MASK)};
  end
endmodule

// File: rtl/phacc_shaper.sv
module phacc_shaper #(
  parameter int RW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [RW-1:0]        r_i,
  output logic signed [RW:0]   d_o
);
  logic [RW-1:0] prev_q;

  // previous sample is zero whenever the shaped dither is idle
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= en_i ? r_i : '0;
  end

  always_comb begin
    if (en_i) d_o = $signed({1'b0, r_i}) - $signed({1'b0, prev_q});
    else      d_o = '0;
  end
endmodule

// File: rtl/phacc_core.sv
module phacc_core #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] inc_i,
  input  logic         ph_en_i,
  input  logic [N-1:0] ph_rand_i,
  output logic [N-1:0] acc_o,
  output logic         ovf_o,
  output logic         sq_o
);
  logic         tog_q;
  logic [N:0]   sum;
  logic         tog_n;
  logic [N:0]   phase_n;
  logic [N:0]   dith_sum;
  logic         sq_n;

  always_comb begin
    sum      = {1'b0, acc_o} + {1'b0, inc_i};
    tog_n    = tog_q ^ sum[N];
    phase_n  = {tog_n, sum[N-1:0]};
    dith_sum = phase_n + {1'b0, ph_rand_i};
    sq_n     = ph_en_i ? dith_sum[N] : tog_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      tog_q <= 1'b0;
      ovf_o <= 1'b0;
      sq_o  <= 1'b0;
    end else begin
      acc_o <= sum[N-1:0];
      tog_q <= tog_n;
      ovf_o <= sum[N];
      sq_o  <= sq_n;
    end
  end
endmodule

// File: rtl/phacc_synth.sv
module phacc_synth #(
  parameter int ACC_W  = 8,
  parameter int FD_W   = 4,
  parameter int LFSR_W = 16,
  parameter int SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] fcw_i,
  input  logic [1:0]       mode_i,
  input  logic             dith_en_i,
  output logic             sq_o,
  output logic             ovf_o,
  output logic [ACC_W-1:0] acc_o
);
  import phacc_pkg::*;

  localparam int EXT_W = ACC_W + 2;
  localparam int SGN_W = EXT_W - (FD_W + 1);

  dith_mode_e          mode_eff;
  logic                ph_act;
  logic                fq_act;
  logic [LFSR_W-1:0]   rnd;
  logic signed [FD_W:0] diff;
  logic [EXT_W-1:0]    inc_full;
  logic [ACC_W-1:0]    inc;

  always_comb begin
    mode_eff = dith_en_i ? dith_mode_e'(mode_i) : MODE_PLAIN;
    ph_act   = (mode_eff == MODE_PHASE);
    fq_act   = (mode_eff == MODE_FREQ);
  end

  phacc_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .state_o (rnd)
  );

  phacc_shaper #(.RW(FD_W)) u_shaper (
    .clk  (clk),
    .rst  (rst),
    .en_i (fq_act),
    .r_i  (rnd[LFSR_W-1 -: FD_W]),
    .d_o  (diff)
  );

  always_comb begin
    inc_full = {2'b00, fcw_i} + {{SGN_W{diff[FD_W]}}, diff};
    inc      = inc_full[ACC_W-1:0];
  end

  phacc_core #(.N(ACC_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (inc),
    .ph_en_i   (ph_act),
    .ph_rand_i (rnd[ACC_W-1:0]),
    .acc_o     (acc_o),
    .ovf_o     (ovf_o),
    .sq_o      (sq_o)
  );
endmodule

// File: rtl/phacc_chk.sv
module phacc_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] fcw_i,
  input logic [1:0]   mode_i,
  input logic         dith_en_i,
  input logic         sq_o,
  input logic         ovf_o,
  input logic [N-1:0] acc_o
);
  logic       fq;
  logic       ph;
  logic       ph_d;
  logic [N:0] carry_sum;

  always_comb begin
    fq        = dith_en_i && (mode_i == 2'b10);
    ph        = dith_en_i && (mode_i == 2'b01);
    carry_sum = {1'b0, acc_o} + {1'b0, fcw_i};
  end

  always_ff @(posedge clk) begin
    if (rst) ph_d <= 1'b0;
    else     ph_d <= ph;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !ovf_o && !sq_o));

  // R2, R6, R8: register advances by the sampled word unless shaped dither is on
  a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
    !fq |=> (acc_o == N'($past(acc_o) + $past(fcw_i))));

  // R3
  a_r3_ovf_carry: assert property (@(posedge clk) disable iff (rst)
    !fq |=> (ovf_o == $past(carry_sum[N])));

  // R4
  a_r4_sq_toggle: assert property (@(posedge clk) disable iff (rst)
    (!ph && !ph_d) |=> (sq_o == ($past(sq_o) ^ ovf_o)));
endmodule

bind phacc_synth phacc_chk #(.N(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fcw_i     (fcw_i),
  .mode_i    (mode_i),
  .dith_en_i (dith_en_i),
  .sq_o      (sq_o),
  .ovf_o     (ovf_o),
  .acc_o     (acc_o)
);

// File: tb/tb_phacc_synth.sv
`timescale 1ns/1ps
module tb_phacc_synth;
  localparam int N  = 8;
  localparam int PW = 1 << N;
  localparam int NV = 10;

  // stimulus table: control word, mode code, dither enable; expected overflows = K
  localparam int VK [NV] = '{1, 37, 128, 255, 37, 100, 37, 200, 15, 240};
  localparam int VM [NV] = '{0,  0,   0,   3,  2,   1,  2,   2,  2,   2};
  localparam int VE [NV] = '{1,  1,   0,   1,  0,   1,  1,   1,  1,   1};

  logic         clk = 0;
  logic         rst = 1;
  logic [N-1:0] fcw = '0;
  logic [1:0]   mode = 2'b00;
  logic         den = 1'b0;
  logic         sq, ovf;
  logic [N-1:0] acc;

  int  checks = 0;
  int  errors = 0;
  int  P = 0;
  bit  carry;

  always #2.5 clk = ~clk;

  phacc_synth dut (
    .clk(clk), .rst(rst), .fcw_i(fcw), .mode_i(mode), .dith_en_i(den),
    .sq_o(sq), .ovf_o(ovf), .acc_o(acc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic model_step(input int k);
    carry = ((P % PW) + k) >= PW;
    P = (P + k) % (2 * PW);
  endtask

  task automatic do_reset;
    rst = 1;
    tick;
    tick;
    rst = 0;
    P = 0;
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    fcw = 8'd200; mode = 2'b00; den = 1'b1;
    do_reset;
    chk(acc == 0 && ovf == 0 && sq == 0, "R1", "state after reset", int'(acc), 0);
    for (int c = 0; c < 3; c++) tick;
    rst = 1;
    tick;
    chk(acc == 0 && ovf == 0 && sq == 0, "R1", "state after mid-run reset",
        int'({ovf, sq, acc}), 0);
    rst = 0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      int  cnt, accbad, sqbad, sqdiff, accdiff;
      bit  isfq, isph;
      string rq;
      fcw  = N'(VK[i]);
      mode = 2'(VM[i]);
      den  = VE[i][0];
      isfq = (VE[i] == 1) && (VM[i] == 2);
      isph = (VE[i] == 1) && (VM[i] == 1);
      rq   = isfq ? "R7" : (isph ? "R6" : ((VE[i] == 0 || VM[i] == 3) ? "R9" : "R5"));
      do_reset;
      cnt = 0; accbad = 0; sqbad = 0; sqdiff = 0; accdiff = 0;
      for (int c = 0; c < PW; c++) begin
        tick;
        model_step(VK[i]);
        cnt += int'(ovf);
        if (int'(acc) != (P % PW)) accdiff++;
        if (int'(acc) != (P % PW) || ovf != carry) accbad++;
        if (int'(sq) != (P >> N)) begin
          if (isph) sqdiff++;
          else sqbad++;
        end
      end
      chk(cnt == VK[i], rq, "overflow count over 2^N cycles", cnt, VK[i]);
      if (!isfq) begin
        chk(accbad == 0, isph ? "R6" : "R2", "acc/ovf mismatching cycles", accbad, 0);
        chk(acc == 0, "R5", "acc after 2^N cycles", int'(acc), 0);
      end else begin
        chk(accdiff > 0, "R7", "cycles where dither moved acc (want >0)", accdiff, 1);
      end
      if (!isph && !isfq)
        chk(sqbad == 0, "R4", "square wave mismatching cycles", sqbad, 0);
      if (isph)
        chk(sqdiff > 0, "R6", "cycles where dither moved sq (want >0)", sqdiff, 1);
    end

    // R8: word change coinciding with the wrap edge, then a further hop
    fcw = 8'd64; mode = 2'b00; den = 1'b0;
    do_reset;
    for (int c = 0; c < 3; c++) tick;
    chk(acc == 8'd192, "R8", "acc before hop", int'(acc), 192);
    fcw = 8'd100;
    tick;
    chk(acc == 8'd36, "R8", "acc at hop edge", int'(acc), 36);
    chk(ovf == 1'b1, "R3", "overflow at hop edge", int'(ovf), 1);
    chk(sq == 1'b1, "R4", "square wave flips at hop edge", int'(sq), 1);
    fcw = 8'd7;
    tick;
    chk(acc == 8'd43 && ovf == 1'b0, "R8", "acc continues after second hop",
        int'(acc), 43);
    chk(sq == 1'b1, "R4", "square wave holds without overflow", int'(sq), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule